// File: doc/BRIEF.md
# Straddled Transmit Beat Framing and Parity Checker

This block observes a 256-bit transmit stream in which one beat can hold the tail of one packet and the head of the next. It can also hold two complete short packets. A 46-bit sideband word travels with each valid beat. It gives the start flags and start pointers, the end flags and end pointers, the per-packet abort flags, and one odd-parity bit for each data byte.

From this the checker keeps track of whether a packet is still open across beats. It also records whether that packet has been poisoned by a parity error or an abort request. In the cycle after a packet's end beat, it raises a nullify flag for that packet.

Byte parity errors also raise a one-cycle uncorrectable-error pulse. Protocol misuse, such as dropping an abort early or starting over an open packet, sets a sticky framing-violation flag. The block only observes the stream and forwards no data.

Top module: `straddle_txchk`

## Requirements
- R1: An active-low synchronous reset drives all four outputs low and forgets any open packet, so a packet start after reset is never flagged as a framing violation.
- R2: Sideband layout: bits 1:0 are start flags (bit 0 means a packet starts, bit 1 means a second packet also starts), bit 2 is the first start pointer, bit 3 is the second start pointer (0 selects byte 0, 1 selects byte 16), bits 5:4 are end flags (bit 0 ends the first packet present in the beat, bit 1 the second), bits 7:6 are abort flags in the same first/second order, bits 10:8 and 13:11 are the first and second end pointers, and bits 45:14 hold the parity bit of data byte 0 to 31.
- R3: With the parity enable high, a valid beat in which any parity bit fails to make its byte plus that bit hold an odd number of ones raises `uncorrErr` for exactly the next cycle. With the enable low, no parity error is ever reported or used for nullify.
- R4: A packet that took a parity error in any of its beats gets a one-cycle nullify in the cycle after its end beat. `nullifyFirst` is used when it is the first packet present in that beat and `nullifySecond` when it is the second.
- R5: When two packets share a beat, bytes below the second packet's start byte belong to the first packet and the rest to the second. The second packet's start is given by the first start pointer when a packet continues into the beat, and by the second start pointer otherwise.
- R6: A packet whose abort flag was high in any of its beats is nullified at its end, whether it ends in the abort beat or carries on to a later end beat.
- R7: An open packet whose abort was high in the previous beat and whose abort is low in the current valid beat sets `framingErr` in the next cycle.
- R8: A packet start while a packet is open, without that open packet ending first in the same beat, sets `framingErr`. The flag then stays high until reset.
- R9: While `txValid` is low, data and sideband have no effect on any output or on the open-packet state.
- R10: The end pointer fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parChkEn | input | 1 | Enables byte parity checking |
| txValid | input | 1 | Beat valid |
| txData | input | 256 | Beat data, byte i in bits 8i+7:8i |
| txSide | input | 46 | Sideband word, layout in R2 |
| nullifyFirst | output | 1 | Nullify for the first packet ending in the previous beat |
| nullifySecond | output | 1 | Nullify for the second packet ending in the previous beat |
| uncorrErr | output | 1 | One-cycle parity error pulse |
| framingErr | output | 1 | Sticky framing violation flag |

## Verification
Every output comes from a single register stage. A result caused by a beat is therefore due exactly one clock edge after the edge that samples that beat.

The bench drives each beat just after a falling edge and waits through one rising edge. It compares the outputs at the following falling edge, before it applies the next beat. Because of this, a check of a pulse shows both its presence for the affected beat and its absence one beat later.

For multi-beat cases, each beat is checked in turn. This shows that a nullify appears only after the end beat and never after the earlier beats of the packet.

// File: rtl/txchk_pkg.sv
`timescale 1ns/1ps
package txchk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic chk;      // parity check active this beat
    logic two;      // two packets present in this beat
    logic splitHi;  // second packet begins in the upper half
  } dpCtl_t;

  // per-beat parity findings returned to control
  typedef struct packed {
    logic anyBad;
    logic badA;     // error in bytes owned by the first packet
    logic badB;     // error in bytes owned by the second packet
  } dpRes_t;
endpackage

// File: rtl/txchk_datapath.sv
`timescale 1ns/1ps
module txchk_datapath
  import txchk_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0]   beatData,
  input  logic [DATA_W/8-1:0] beatPar,
  input  dpCtl_t              dpCtl,
  output dpRes_t              dpRes
);
  localparam int BYTES = DATA_W / 8;
  localparam int HALF  = BYTES / 2;

  logic [BYTES-1:0] byteBad;
  logic [BYTES-1:0] ownB;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    // odd parity: byte ones plus parity bit must be odd
    assign byteBad[i] = dpCtl.chk & ~(^{beatData[8*i +: 8], beatPar[i]});
    if (i >= HALF) begin : g_hi
      assign ownB[i] = dpCtl.two;
    end else begin : g_lo
      assign ownB[i] = dpCtl.two & ~dpCtl.splitHi;
    end
  end

  assign dpRes.anyBad = |byteBad;
  assign dpRes.badA   = |(byteBad & ~ownB);
  assign dpRes.badB   = |(byteBad & ownB);
endmodule

// File: rtl/txchk_control.sv
`timescale 1ns/1ps
module txchk_control
  import txchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       parChkEn,
  input  logic       beatValid,
  input  logic [1:0] sopFlags,
  input  logic       sopPtrA,
  input  logic       sopPtrB,
  input  logic [1:0] eopFlags,
  input  logic [1:0] abortFlags,
  input  dpRes_t     dpRes,
  output dpCtl_t     dpCtl,
  output logic [1:0] nullify,
  output logic       uncorrErr,
  output logic       framingErr
);
  logic       openQ, poisonQ, abortQ;
  logic       openN, poisonN, abortN;
  logic [1:0] startCnt;
  logic [1:0] pktCnt;
  logic       poisonA, poisonB;
  logic       badStart, abortDrop;

  always_comb begin
    startCnt = sopFlags[0] ? (sopFlags[1] ? 2'd2 : 2'd1) : 2'd0;
    pktCnt   = {1'b0, openQ} + startCnt;

    dpCtl.chk     = beatValid & parChkEn;
    dpCtl.two     = (pktCnt >= 2'd2);
    dpCtl.splitHi = openQ ? sopPtrA : sopPtrB;

    poisonA = (openQ & poisonQ) | dpRes.badA | abortFlags[0];
    poisonB = dpRes.badB | abortFlags[1];

    badStart  = openQ & sopFlags[0] & (~eopFlags[0] | sopFlags[1]);
    abortDrop = openQ & abortQ & ~abortFlags[0];

    openN   = openQ;
    poisonN = poisonQ;
    abortN  = abortQ;
    if (pktCnt == 2'd1) begin
      openN   = ~eopFlags[0];
      poisonN = poisonA;
      abortN  = abortFlags[0];
    end else if (pktCnt >= 2'd2) begin
      openN   = ~eopFlags[1];
      poisonN = poisonB;
      abortN  = abortFlags[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ      <= 1'b0;
      poisonQ    <= 1'b0;
      abortQ     <= 1'b0;
      nullify    <= 2'b00;
      uncorrErr  <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      uncorrErr <= dpRes.anyBad;
      nullify   <= 2'b00;
      if (beatValid) begin
        nullify[0] <= eopFlags[0] & poisonA & (pktCnt != 2'd0);
        nullify[1] <= eopFlags[1] & poisonB & dpCtl.two;
        openQ      <= openN;
        poisonQ    <= poisonN & openN;
        abortQ     <= abortN & openN;
        framingErr <= framingErr | badStart | abortDrop;
      end
    end
  end

  // R4: a first-slot nullify follows a valid beat that ended a first packet
  assert_null_first_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    nullify[0] |-> $past(beatValid && eopFlags[0]));

  // R4: a second-slot nullify follows a valid beat that ended a second packet
  assert_null_second_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    nullify[1] |-> $past(beatValid && eopFlags[1]));

  // R3: the error pulse needs a valid beat with checking enabled
  assert_uerr_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    uncorrErr |-> $past(beatValid && parChkEn));

  // R6: an aborted packet ending in this beat is nullified next cycle
  assert_abort_nullify_R6: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && eopFlags[0] && abortFlags[0] && pktCnt != 2'd0) |=> nullify[0]);

  // R7: dropping a held abort is flagged
  assert_abort_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && openQ && abortQ && !abortFlags[0]) |=> framingErr);

  // R8: the framing flag holds until reset
  assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |=> framingErr);
endmodule

// File: rtl/straddle_txchk.sv
`timescale 1ns/1ps
module straddle_txchk
  import txchk_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    parChkEn,
  input  logic                    txValid,
  input  logic [DATA_W-1:0]       txData,
  input  logic [14+DATA_W/8-1:0]  txSide,
  output logic                    nullifyFirst,
  output logic                    nullifySecond,
  output logic                    uncorrErr,
  output logic                    framingErr
);
  localparam int BYTES   = DATA_W / 8;
  localparam int SOP_LSB = 0;
  localparam int SPA_BIT = 2;
  localparam int SPB_BIT = 3;
  localparam int EOP_LSB = 4;
  localparam int ABT_LSB = 6;
  localparam int EPT_LSB = 8;
  localparam int PAR_LSB = 14;

  dpCtl_t     dpCtl;
  dpRes_t     dpRes;
  logic [1:0] nullify;
  logic       unusedEndPtr;

  // end pointers carry no meaning for this check
  assign unusedEndPtr = ^txSide[EPT_LSB +: 6];

  txchk_datapath #(.DATA_W(DATA_W)) u_datapath (
    .beatData (txData),
    .beatPar  (txSide[PAR_LSB +: BYTES]),
    .dpCtl    (dpCtl),
    .dpRes    (dpRes)
  );

  txchk_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .parChkEn   (parChkEn),
    .beatValid  (txValid),
    .sopFlags   (txSide[SOP_LSB +: 2]),
    .sopPtrA    (txSide[SPA_BIT]),
    .sopPtrB    (txSide[SPB_BIT]),
    .eopFlags   (txSide[EOP_LSB +: 2]),
    .abortFlags (txSide[ABT_LSB +: 2]),
    .dpRes      (dpRes),
    .dpCtl      (dpCtl),
    .nullify    (nullify),
    .uncorrErr  (uncorrErr),
    .framingErr (framingErr)
  );

  assign nullifyFirst  = nullify[0];
  assign nullifySecond = nullify[1];
endmodule

// File: tb/straddle_txchk_tb.sv
`timescale 1ns/1ps
module straddle_txchk_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         parChkEn;
  logic         txValid;
  logic [255:0] txData;
  logic [45:0]  txSide;
  logic         nullifyFirst, nullifySecond, uncorrErr, framingErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  straddle_txchk u_dut (
    .clk(clk), .rstN(rstN), .parChkEn(parChkEn), .txValid(txValid),
    .txData(txData), .txSide(txSide), .nullifyFirst(nullifyFirst),
    .nullifySecond(nullifySecond), .uncorrErr(uncorrErr), .framingErr(framingErr)
  );

  function automatic logic [45:0] mk(input logic [1:0] sop, input logic pa, input logic pb,
                                     input logic [1:0] eop, input logic [1:0] abt,
                                     input logic [2:0] ea, input logic [2:0] eb,
                                     input logic [31:0] par);
    return {par, eb, ea, abt, eop, pb, pa, sop};
  endfunction

  function automatic logic [31:0] goodPar(input logic [255:0] d);
    logic [31:0] p;
    for (int i = 0; i < 32; i++) p[i] = ~(^d[8*i +: 8]);
    return p;
  endfunction

  function automatic logic [255:0] pat(input int b);
    return {8{32'h5A3C_9617 ^ (b * 32'h0101_0101)}};
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic expectAll(input string req, input logic nf, input logic ns,
                           input logic ue, input logic fe);
    chk(req, "nullifyFirst", nullifyFirst, nf);
    chk(req, "nullifySecond", nullifySecond, ns);
    chk(req, "uncorrErr", uncorrErr, ue);
    chk(req, "framingErr", framingErr, fe);
  endtask

  task automatic beat(input logic [255:0] d, input logic [45:0] sb);
    txValid = 1'b1;
    txData  = d;
    txSide  = sb;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic idle();
    txValid = 1'b0;
    txData  = ~pat(3);
    txSide  = mk(2'b11, 1'b1, 1'b1, 2'b11, 2'b11, 3'd5, 3'd2, 32'h0);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    txValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] d;
    logic [31:0]  p;
    rstN = 1'b0; parChkEn = 1'b1; txValid = 1'b0; txData = '0; txSide = '0;
    repeat (2) @(negedge clk);
    expectAll("R1", 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4 R10: single-beat packet, error swept over every byte, end pointers varied
    for (int b = 0; b < 32; b++) begin
      d = pat(b); p = goodPar(d) ^ (32'd1 << b);
      beat(d, mk(2'b01, 1'b0, 1'b0, 2'b01, 2'b00, 3'(b % 8), 3'(7 - b % 8), p));
      expectAll("R4", 1, 0, 1, 0);
      idle();
      expectAll("R3", 0, 0, 0, 0);
    end

    // R10 R2: clean single-beat packets with all end pointer values
    for (int e = 0; e < 8; e++) begin
      d = pat(e + 40);
      beat(d, mk(2'b01, 1'b0, 1'b0, 2'b01, 2'b00, 3'(e), 3'(e), goodPar(d)));
      expectAll("R10", 0, 0, 0, 0);
    end

    // R5: two packets start in one beat, second at byte 16
    for (int b = 0; b < 32; b++) begin
      d = pat(b + 7); p = goodPar(d) ^ (32'd1 << b);
      beat(d, mk(2'b11, 1'b0, 1'b1, 2'b11, 2'b00, 3'd3, 3'd7, p));
      expectAll("R5", b < 16, b >= 16, 1, 0);
    end

    // R5: continuing packet ends and a new one starts at byte 16 in the same beat
    for (int b = 0; b < 32; b++) begin
      d = pat(b + 3);
      beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
      expectAll("R5", 0, 0, 0, 0);
      p = goodPar(d) ^ (32'd1 << b);
      beat(d, mk(2'b01, 1'b1, 1'b0, 2'b11, 2'b00, 3'd3, 3'd7, p));
      expectAll("R5", b < 16, b >= 16, 1, 0);
    end

    // R4: error in an early beat nullifies only after the end beat
    for (int b = 0; b < 32; b += 5) begin
      d = pat(b + 11); p = goodPar(d) ^ (32'd1 << b);
      beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, p));
      expectAll("R4", 0, 0, 1, 0);
      beat(d, mk(2'b00, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
      expectAll("R4", 0, 0, 0, 0);
      beat(d, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b00, 3'd6, 3'd0, goodPar(d)));
      expectAll("R4", 1, 0, 0, 0);
    end

    // R3: enable low suppresses both the pulse and the nullify
    parChkEn = 1'b0;
    for (int b = 0; b < 32; b++) begin
      d = pat(b); p = goodPar(d) ^ (32'd1 << b);
      beat(d, mk(2'b11, 1'b0, 1'b1, 2'b11, 2'b00, 3'd3, 3'd7, p));
      expectAll("R3", 0, 0, 0, 0);
    end
    parChkEn = 1'b1;

    // R6: abort raised mid-packet, held, packet carried to its end
    d = pat(50);
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    beat(d, mk(2'b00, 1'b0, 1'b0, 2'b00, 2'b01, 3'd0, 3'd0, goodPar(d)));
    expectAll("R6", 0, 0, 0, 0);
    beat(d, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b01, 3'd4, 3'd0, goodPar(d)));
    expectAll("R6", 1, 0, 0, 0);
    // R6: early end in the abort beat
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    beat(d, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b01, 3'd1, 3'd0, goodPar(d)));
    expectAll("R6", 1, 0, 0, 0);
    // R6: abort only on the second of two packets
    beat(d, mk(2'b11, 1'b0, 1'b1, 2'b11, 2'b10, 3'd3, 3'd7, goodPar(d)));
    expectAll("R6", 0, 1, 0, 0);

    // R9: invalid beats with loud sideband and bad parity change nothing
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    txValid = 1'b0; txData = d;
    txSide = mk(2'b11, 1'b1, 1'b1, 2'b11, 2'b11, 3'd2, 3'd2, ~goodPar(d));
    @(negedge clk);
    expectAll("R9", 0, 0, 0, 0);
    beat(d, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b00, 3'd7, 3'd0, goodPar(d)));
    expectAll("R9", 0, 0, 0, 0);

    // R7: abort dropped before the packet end
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b01, 3'd0, 3'd0, goodPar(d)));
    expectAll("R7", 0, 0, 0, 0);
    beat(d, mk(2'b00, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    expectAll("R7", 0, 0, 0, 1);
    idle();
    expectAll("R8", 0, 0, 0, 1);
    doReset();
    @(negedge clk);
    expectAll("R1", 0, 0, 0, 0);

    // R8: start over an open packet, then sticky
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    expectAll("R8", 0, 0, 0, 0);
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    expectAll("R8", 0, 0, 0, 1);
    idle(); idle();
    expectAll("R8", 0, 0, 0, 1);

    // R1: reset forgets an open packet
    doReset();
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    doReset();
    beat(d, mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 3'd0, goodPar(d)));
    expectAll("R1", 0, 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule